// File: doc/BRIEF.md
# Paged 24-bit Address Generator

This block forms every memory address a small 16-bit processor puts on its 24-bit bus. An address is an 8-bit page byte on bits 23:16 joined to a 16-bit offset on bits 15:0. The block keeps four pointer pairs, each a page byte plus an offset word. It also keeps an offset latch, which is loaded from an instruction immediate, from a computed index, or from a trap number scaled to a vector slot. A 4-bit source code from the control unit picks which page and offset drive the bus.

Pair 3 serves as the implicit stack pointer, so it can be switched as a whole on each task change. A dedicated source code forces the page byte to zero while the offset latch still supplies the low half. Interrupt and trap vector fetches use it, and so do kernel data accesses, so none of them depends on the page that the current task has loaded into pair 3. A page-relative source takes its page from a selected pair and its offset from the latch. One instruction bit turns that same access into a forced-zero-page access.

The block also performs the 24-bit pointer step. It adds an amount to, or subtracts an amount from, a pair's offset and carries or borrows into the pair's page byte. Both halves are written on one clock edge, and the result is also returned on a registered output.

Top module: `pag_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears all four pointer pairs, the offset latch and the registered step result to zero.
- R2: Source codes 0 to 3 drive the address as {page, offset} of the pair with that number (pair 3 is the stack pair). A pair written through the load port appears on the address from the next cycle.
- R3: When the latch enable is high, the offset latch takes its value on the clock edge. The latch source codes are: 0 loads the immediate, 1 loads the index, 2 loads the immediate's low 8 bits multiplied by 4 (trap vector slot), and 3 leaves the latch unchanged.
- R4: Source code 4 with the zero-page instruction bit low drives {page of the pair chosen by the page-select input, offset latch}.
- R5: Source code 4 with the zero-page instruction bit high drives {8'h00, offset latch}, whatever the chosen pair holds.
- R6: Source code 5 drives {8'h00, offset latch} regardless of every pair's page byte. An interrupt vector therefore reads 24'h000000, and trap n reads 24'h000000 + 4n.
- R7: Source codes 6 to 15 drive the address to zero and raise the decode-error output. For codes 0 to 5 the decode-error output is low.
- R8: A pointer increment adds the 16-bit amount to the pair's offset, and the carry out of bit 15 increments the page byte, wrapping modulo 2^24.
- R9: A pointer decrement subtracts the amount from the offset, and a borrow decrements the page byte, wrapping modulo 2^24.
- R10: A step writes page and offset of the stepped pair on the same edge, presents the new 24-bit value on the registered step-result output from the next cycle, and leaves the other pairs unchanged.
- R11: When a load and a step target the same pair in one cycle, the load wins and the step result output keeps its previous value. When they target different pairs, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write a pointer pair from the load port |
| ld_sel | input | 2 | Pair to write |
| ld_page | input | 8 | Page byte to write |
| ld_off | input | 16 | Offset to write |
| lat_en | input | 1 | Load the offset latch |
| lat_src | input | 2 | Latch source: 0 immediate, 1 index, 2 vector slot, 3 hold |
| imm | input | 16 | Instruction immediate |
| idx | input | 16 | Computed index |
| src_code | input | 4 | Address source code |
| pr_sel | input | 2 | Pair supplying the page for page-relative access |
| zp_bit | input | 1 | Instruction bit selecting the forced-zero-page variant |
| step_en | input | 1 | Perform a pointer step |
| step_sel | input | 2 | Pair to step |
| step_dec | input | 1 | 1 decrement, 0 increment |
| step_amt | input | 16 | Step amount |
| addr_o | output | 24 | Memory address |
| dec_err_o | output | 1 | Unused source code seen |
| upd_o | output | 24 | Registered result of the last step |

## Verification
The pairs are loaded with distinct, non-zero page bytes. A wrong pair selection or a leaked page then shows up in the address. Forced-zero and page-relative accesses are run with pair 3 holding a non-zero page, which separates a true zero page from the stack pair's page. Steps are tried without a carry, with a carry into the page, with a borrow out of the page, and with a wrap of the full 24 bits; these separate a 16-bit adder from a chained 24-bit one. A load and a step aimed at the same pair, and then at different pairs, show the priority between them.

// File: rtl/pag_pkg.sv
package pag_pkg;
    parameter int PAGE_W    = 8;
    parameter int OFF_W     = 16;
    parameter int NPAIR     = 4;
    parameter int SRC_W     = 4;
    parameter int VEC_W     = 8;
    parameter int VEC_SHIFT = 2;

    localparam int ADDR_W = PAGE_W + OFF_W;
    localparam int SEL_W  = $clog2(NPAIR);

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        page_t page;
        off_t  off;
    } ptr_t;

    typedef enum logic [1:0] {
        OL_IMM  = 2'd0,
        OL_IDX  = 2'd1,
        OL_VEC  = 2'd2,
        OL_HOLD = 2'd3
    } olat_src_e;

    localparam logic [SRC_W-1:0] SRC_PAGEREL = SRC_W'(NPAIR);
    localparam logic [SRC_W-1:0] SRC_ZERO    = SRC_W'(NPAIR + 1);

    // Chained step: offset arithmetic first, its carry/borrow then moves the page.
    function automatic ptr_t ptr_step(ptr_t p, off_t amt, logic dec);
        logic [OFF_W:0] s;
        ptr_t r;
        if (dec) s = {1'b0, p.off} - {1'b0, amt};
        else     s = {1'b0, p.off} + {1'b0, amt};
        r.off = s[OFF_W-1:0];
        if (dec) r.page = p.page - page_t'(s[OFF_W]);
        else     r.page = p.page + page_t'(s[OFF_W]);
        return r;
    endfunction

    function automatic off_t vec_offset(off_t raw);
        return off_t'(raw[VEC_W-1:0]) << VEC_SHIFT;
    endfunction
endpackage

// File: rtl/pag_ptr_file.sv
module pag_ptr_file
    import pag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  ptr_t             ld_val,
    input  logic             st_en,
    input  logic [SEL_W-1:0] st_sel,
    input  logic             st_dec,
    input  off_t             st_amt,
    output ptr_t             pairs [NPAIR],
    output ptr_t             upd_q
);
    ptr_t regs_q [NPAIR];
    ptr_t step_val;
    logic st_blocked;

    assign step_val   = ptr_step(regs_q[st_sel], st_amt, st_dec);
    assign st_blocked = ld_en && (ld_sel == st_sel);

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst)                                      regs_q[g] <= '0;
            else if (ld_en && ld_sel == SEL_W'(g))        regs_q[g] <= ld_val;
            else if (st_en && st_sel == SEL_W'(g))        regs_q[g] <= step_val;
        end
        assign pairs[g] = regs_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)                       upd_q <= '0;
        else if (st_en && !st_blocked) upd_q <= step_val;
    end

    // R10: the stepped pair and the step result agree after the edge
    assert_step_atomic_R10: assert property (@(posedge clk) disable iff (rst)
        (st_en && !st_blocked) |=> (regs_q[$past(st_sel)] == upd_q));

    // R11: a load always lands, even against a step on the same pair
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (regs_q[$past(ld_sel)] == $past(ld_val)));

    // R11: a blocked step leaves the step result untouched
    assert_blocked_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (st_en && st_blocked) |=> $stable(upd_q));
endmodule

// File: rtl/pag_off_latch.sv
module pag_off_latch
    import pag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  olat_src_e src,
    input  off_t      imm,
    input  off_t      idx,
    output off_t      lat_q
);
    off_t nxt;

    always_comb begin
        unique case (src)
            OL_IMM:  nxt = imm;
            OL_IDX:  nxt = idx;
            OL_VEC:  nxt = vec_offset(imm);
            default: nxt = lat_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     lat_q <= '0;
        else if (en) lat_q <= nxt;
    end

    // R3: immediate source captured on the edge
    assert_lat_imm_R3: assert property (@(posedge clk) disable iff (rst)
        (en && src == OL_IMM) |=> (lat_q == $past(imm)));

    // R3: hold source leaves the latch untouched
    assert_lat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (en && src == OL_HOLD) |=> $stable(lat_q));
endmodule

// File: rtl/pag_addr_mux.sv
module pag_addr_mux
    import pag_pkg::*;
(
    input  ptr_t             pairs [NPAIR],
    input  off_t             lat,
    input  logic [SRC_W-1:0] src,
    input  logic [SEL_W-1:0] pr_sel,
    input  logic             zp_bit,
    output logic [ADDR_W-1:0] addr,
    output logic             err
);
    logic [ADDR_W-1:0] pair_addr [NPAIR];

    for (genvar g = 0; g < NPAIR; g++) begin : g_src
        assign pair_addr[g] = {pairs[g].page, pairs[g].off};
    end

    always_comb begin
        addr = '0;
        err  = 1'b0;
        if (src < SRC_W'(NPAIR)) begin
            addr = pair_addr[src[SEL_W-1:0]];
        end else if (src == SRC_PAGEREL) begin
            addr = {(zp_bit ? page_t'(0) : pairs[pr_sel].page), lat};
        end else if (src == SRC_ZERO) begin
            addr = {page_t'(0), lat};
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/pag_addr_gen.sv
module pag_addr_gen
    import pag_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_en,
    input  logic [SEL_W-1:0]        ld_sel,
    input  logic [PAGE_W-1:0]       ld_page,
    input  logic [OFF_W-1:0]        ld_off,
    input  logic                    lat_en,
    input  logic [1:0]              lat_src,
    input  logic [OFF_W-1:0]        imm,
    input  logic [OFF_W-1:0]        idx,
    input  logic [SRC_W-1:0]        src_code,
    input  logic [SEL_W-1:0]        pr_sel,
    input  logic                    zp_bit,
    input  logic                    step_en,
    input  logic [SEL_W-1:0]        step_sel,
    input  logic                    step_dec,
    input  logic [OFF_W-1:0]        step_amt,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    dec_err_o,
    output logic [ADDR_W-1:0]       upd_o
);
    ptr_t pairs [NPAIR];
    ptr_t upd_q;
    off_t lat_q;
    ptr_t ld_val;

    assign ld_val = '{page: ld_page, off: ld_off};

    pag_ptr_file u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_val (ld_val),
        .st_en  (step_en),
        .st_sel (step_sel),
        .st_dec (step_dec),
        .st_amt (step_amt),
        .pairs  (pairs),
        .upd_q  (upd_q)
    );

    pag_off_latch u_lat (
        .clk   (clk),
        .rst   (rst),
        .en    (lat_en),
        .src   (olat_src_e'(lat_src)),
        .imm   (imm),
        .idx   (idx),
        .lat_q (lat_q)
    );

    pag_addr_mux u_mux (
        .pairs  (pairs),
        .lat    (lat_q),
        .src    (src_code),
        .pr_sel (pr_sel),
        .zp_bit (zp_bit),
        .addr   (addr_o),
        .err    (dec_err_o)
    );

    assign upd_o = upd_q;

    // R6: forced-zero source never carries a page byte
    assert_zero_page_R6: assert property (@(posedge clk) disable iff (rst)
        (src_code == SRC_ZERO) |-> (addr_o == {page_t'(0), lat_q}));

    // R5: page-relative with the zero bit set ignores the chosen pair
    assert_pagerel_zp_R5: assert property (@(posedge clk) disable iff (rst)
        (src_code == SRC_PAGEREL && zp_bit) |-> (addr_o[ADDR_W-1:OFF_W] == '0));

    // R7: an error always comes with a zero address
    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
        dec_err_o |-> (addr_o == '0));

    // R7: defined codes never flag an error
    assert_no_err_R7: assert property (@(posedge clk) disable iff (rst)
        (src_code <= SRC_ZERO) |-> !dec_err_o);

    // R2: stack pair source tracks pair 3
    assert_stack_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (src_code == SRC_W'(NPAIR - 1)) |-> (addr_o == {pairs[NPAIR-1].page, pairs[NPAIR-1].off}));

    // R1: reset clears the step result
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (upd_o == '0));
endmodule

// File: tb/pag_addr_gen_tb_top.sv
module pag_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [1:0]  ld_sel;
    logic [7:0]  ld_page;
    logic [15:0] ld_off;
    logic        lat_en;
    logic [1:0]  lat_src;
    logic [15:0] imm;
    logic [15:0] idx;
    logic [3:0]  src_code;
    logic [1:0]  pr_sel;
    logic        zp_bit;
    logic        step_en;
    logic [1:0]  step_sel;
    logic        step_dec;
    logic [15:0] step_amt;
    logic [23:0] addr_o;
    logic        dec_err_o;
    logic [23:0] upd_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [23:0] model [4];

    always #5 clk = ~clk;

    pag_addr_gen dut_i (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_page(ld_page), .ld_off(ld_off),
        .lat_en(lat_en), .lat_src(lat_src), .imm(imm), .idx(idx),
        .src_code(src_code), .pr_sel(pr_sel), .zp_bit(zp_bit),
        .step_en(step_en), .step_sel(step_sel), .step_dec(step_dec), .step_amt(step_amt),
        .addr_o(addr_o), .dec_err_o(dec_err_o), .upd_o(upd_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 0; lat_en = 0; step_en = 0;
    endtask

    task automatic load_pair(input int k, input logic [7:0] p, input logic [15:0] o);
        @(negedge clk);
        ld_en = 1; ld_sel = 2'(k); ld_page = p; ld_off = o;
        @(negedge clk);
        idle();
        model[k] = {p, o};
    endtask

    task automatic set_latch(input logic [1:0] s, input logic [15:0] i, input logic [15:0] x);
        @(negedge clk);
        lat_en = 1; lat_src = s; imm = i; idx = x;
        @(negedge clk);
        idle();
    endtask

    task automatic do_step(input int k, input logic dec, input logic [15:0] amt);
        @(negedge clk);
        step_en = 1; step_sel = 2'(k); step_dec = dec; step_amt = amt;
        @(negedge clk);
        idle();
    endtask

    task automatic chk_addr(input string req, input logic [3:0] s, input logic [1:0] ps,
                            input logic zb, input logic [23:0] exp);
        src_code = s; pr_sel = ps; zp_bit = zb;
        #1;
        chk(req, 32'(addr_o), 32'(exp));
    endtask

    task automatic t_reset();
        chk_addr("R1 pair0", 4'd0, 2'd0, 1'b0, 24'h0);
        chk_addr("R1 pair3", 4'd3, 2'd0, 1'b0, 24'h0);
        chk_addr("R1 latch", 4'd5, 2'd0, 1'b0, 24'h0);
        chk("R1 upd", 32'(upd_o), 32'h0);
        chk("R1 err", 32'(dec_err_o), 32'h0);
    endtask

    task automatic t_pairs();
        load_pair(0, 8'h11, 16'h1000);
        load_pair(1, 8'h22, 16'h2001);
        load_pair(2, 8'h33, 16'h3002);
        load_pair(3, 8'h44, 16'hFF00);
        for (int k = 0; k < 4; k++) chk_addr("R2 pair source", 4'(k), 2'd0, 1'b0, model[k]);
    endtask

    task automatic t_latch();
        set_latch(2'd0, 16'h0108, 16'h7777);
        chk_addr("R3 imm source", 4'd5, 2'd0, 1'b0, 24'h000108);
        set_latch(2'd1, 16'h0000, 16'hABCD);
        chk_addr("R3 idx source", 4'd5, 2'd0, 1'b0, 24'h00ABCD);
        set_latch(2'd3, 16'hBEEF, 16'hBEEF);
        chk_addr("R3 hold source", 4'd5, 2'd0, 1'b0, 24'h00ABCD);
        set_latch(2'd2, 16'hFF05, 16'h0);
        chk_addr("R3 R6 trap 5 vector", 4'd5, 2'd0, 1'b0, 24'h000014);
        set_latch(2'd2, 16'h0000, 16'h0);
        chk_addr("R6 interrupt vector", 4'd5, 2'd0, 1'b0, 24'h000000);
    endtask

    task automatic t_pagerel();
        set_latch(2'd0, 16'h0108, 16'h0);
        chk_addr("R4 page-rel pair3", 4'd4, 2'd3, 1'b0, 24'h440108);
        chk_addr("R4 page-rel pair1", 4'd4, 2'd1, 1'b0, 24'h220108);
        chk_addr("R5 page-rel zero bit", 4'd4, 2'd3, 1'b1, 24'h000108);
        chk_addr("R6 zero source ignores pair3", 4'd5, 2'd3, 1'b0, 24'h000108);
        chk("R7 no err code4", 32'(dec_err_o), 32'h0);
    endtask

    task automatic t_unused();
        for (int c = 6; c < 16; c++) begin
            chk_addr("R7 unused addr", 4'(c), 2'd3, 1'b0, 24'h0);
            chk("R7 unused err", 32'(dec_err_o), 32'h1);
        end
    endtask

    task automatic t_steps();
        load_pair(1, 8'h12, 16'h0010);
        do_step(1, 1'b0, 16'd4);
        chk("R8 inc no carry upd", 32'(upd_o), 32'h120014);
        chk_addr("R8 inc no carry addr", 4'd1, 2'd0, 1'b0, 24'h120014);
        load_pair(1, 8'h12, 16'hFFFE);
        do_step(1, 1'b0, 16'd4);
        chk("R8 inc carry upd", 32'(upd_o), 32'h130002);
        chk_addr("R10 inc carry both halves", 4'd1, 2'd0, 1'b0, 24'h130002);
        chk_addr("R10 pair0 untouched", 4'd0, 2'd0, 1'b0, model[0]);
        chk_addr("R10 pair2 untouched", 4'd2, 2'd0, 1'b0, model[2]);
        do_step(1, 1'b1, 16'd4);
        chk("R9 dec borrow upd", 32'(upd_o), 32'h12FFFE);
        chk_addr("R9 dec borrow addr", 4'd1, 2'd0, 1'b0, 24'h12FFFE);
        load_pair(2, 8'hFF, 16'hFFFF);
        do_step(2, 1'b0, 16'd1);
        chk("R8 24-bit wrap up", 32'(upd_o), 32'h000000);
        do_step(2, 1'b1, 16'd1);
        chk("R9 24-bit wrap down", 32'(upd_o), 32'hFFFFFF);
    endtask

    task automatic t_priority();
        @(negedge clk);
        ld_en = 1; ld_sel = 2'd0; ld_page = 8'h5A; ld_off = 16'h0100;
        step_en = 1; step_sel = 2'd0; step_dec = 1'b0; step_amt = 16'h0010;
        @(negedge clk);
        idle();
        chk_addr("R11 load beats step", 4'd0, 2'd0, 1'b0, 24'h5A0100);
        chk("R11 blocked upd holds", 32'(upd_o), 32'hFFFFFF);
        @(negedge clk);
        ld_en = 1; ld_sel = 2'd3; ld_page = 8'h66; ld_off = 16'h0200;
        step_en = 1; step_sel = 2'd0; step_dec = 1'b0; step_amt = 16'h0010;
        @(negedge clk);
        idle();
        chk_addr("R11 both: step pair0", 4'd0, 2'd0, 1'b0, 24'h5A0110);
        chk_addr("R11 both: load pair3", 4'd3, 2'd0, 1'b0, 24'h660200);
        chk("R11 both: upd", 32'(upd_o), 32'h5A0110);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1; idle();
        ld_sel = 0; ld_page = 0; ld_off = 0; lat_src = 0; imm = 0; idx = 0;
        src_code = 0; pr_sel = 0; zp_bit = 0; step_sel = 0; step_dec = 0; step_amt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_pairs();
        t_latch();
        t_pagerel();
        t_unused();
        t_steps();
        t_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule